// File: doc/BRIEF.md
# Two-Port Register File with Output Latches

This block is a small register file with two read ports and one write port. Port B carries the address used both for writing and for reading, and port A is a read-only address. A single data input is written into the word selected by port B when two active-low write strobes are both asserted in the same cycle. Each read port feeds its own output latch, and each latch drives an output whose enable is active-low and which reports a valid flag in place of a high-impedance state.

While a write is in flight, the read path bypasses the array. Port B always shows the incoming data, and port A shows it only when its address matches the write address. The output latches are clock-enabled registers. With the latch-open input high they load on every clock edge. With it low they hold, so a caller can freeze read data before starting a write. Only the A latch has an active-low clear, which forces its outputs to zero.

Top module: `twin_port_regbank`

## Requirements
- R1: While `rst_n` is low, both output latches are cleared to zero. After reset, with both output enables low, `qa` and `qb` read 0.
- R2: On a rising clock edge, `din` is stored into the word selected by `addr_b` only if `wr0_n` and `wr1_n` are both low. If either strobe is high, no word changes.
- R3: During a write cycle, the B latch input is `din`. The A latch input is also `din` when `addr_a` equals `addr_b`, and is otherwise the stored word at `addr_a`.
- R4: With no write active, the A latch input is the stored word at `addr_a` and the B latch input is the stored word at `addr_b`.
- R5: With `lat_open` high, both latches load their inputs on every rising edge, so a value appears on the outputs one edge after it is presented. With `lat_open` low, both latches keep their contents whatever the addresses, data or write activity.
- R6: When `clr_a_n` is low at a rising edge, the A latch becomes zero, whatever the levels of `lat_open` and `oe_a_n`, and it takes priority over loading. The B latch is not affected by `clr_a_n`.
- R7: When `oe_a_n` (or `oe_b_n`) is high, `qa_vld` (or `qb_vld`) is 0 and the data output reads 0 in the same cycle. The latch contents are kept and reappear when the enable returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the array and the output latches |
| rst_n | input | 1 | Asynchronous active-low reset of both output latches |
| addr_a | input | 4 | Read address of port A |
| addr_b | input | 4 | Write and read address of port B |
| din | input | 4 | Write data |
| wr0_n | input | 1 | First active-low write strobe |
| wr1_n | input | 1 | Second active-low write strobe |
| lat_open | input | 1 | High: latches load each edge; low: latches hold |
| clr_a_n | input | 1 | Active-low clear of the A latch |
| oe_a_n | input | 1 | Active-low output enable of port A |
| oe_b_n | input | 1 | Active-low output enable of port B |
| qa | output | 4 | Port A data; 0 when disabled |
| qa_vld | output | 1 | Port A output enabled |
| qb | output | 4 | Port B data; 0 when disabled |
| qb_vld | output | 1 | Port B output enabled |

## Verification
The hardest case to reach is a latch that keeps old read data while a write to the same word goes on underneath it. The stimulus has to load the latch, close it, and only then assert both strobes on the held address, and the same word must afterwards be read again to show that the write did land. The clear is checked the same way: it is applied to a latch that is holding a nonzero value, once with the latch closed and once with it open, while port B holds its own distinct value so that any leak of the clear onto port B shows up.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;
  localparam int unsigned TP_WORDS = 16;
  localparam int unsigned TP_WIDTH = 4;

  typedef enum logic {
    SRC_STORED   = 1'b0,
    SRC_INFLIGHT = 1'b1
  } rd_src_e;
endpackage

// File: rtl/tpr_storage.sv
module tpr_storage #(
  parameter int unsigned WORDS = twin_port_pkg::TP_WORDS,
  parameter int unsigned WIDTH = twin_port_pkg::TP_WIDTH,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    waddr_i,
  input  logic [AW-1:0]    raddr_a_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             wr0_n_i,
  input  logic             wr1_n_i,
  output logic             wr_fire_o,
  output logic [WIDTH-1:0] rdata_a_o,
  output logic [WIDTH-1:0] rdata_b_o
);
  logic [WORDS-1:0][WIDTH-1:0] mem;

  // both strobes must be low together
  assign wr_fire_o = ~wr0_n_i & ~wr1_n_i;

  always_ff @(posedge clk) begin
    if (wr_fire_o) mem[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[waddr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire_o |=> (mem[$past(waddr_i)] == $past(wdata_i))); // R2
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire_o |=> $stable(mem)); // R2
endmodule

// File: rtl/tpr_bypass.sv
module tpr_bypass
  import twin_port_pkg::*;
#(
  parameter int unsigned WORDS = TP_WORDS,
  parameter int unsigned WIDTH = TP_WIDTH,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_a_i,
  input  logic [AW-1:0]    addr_b_i,
  input  logic             wr_fire_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] stored_a_i,
  input  logic [WIDTH-1:0] stored_b_i,
  output logic [WIDTH-1:0] next_a_o,
  output logic [WIDTH-1:0] next_b_o
);
  rd_src_e src_a;
  rd_src_e src_b;

  function automatic logic [WIDTH-1:0] pick_word(rd_src_e src,
                                                 logic [WIDTH-1:0] stored,
                                                 logic [WIDTH-1:0] inflight);
    return (src == SRC_INFLIGHT) ? inflight : stored;
  endfunction

  always_comb begin
    src_b = wr_fire_i ? SRC_INFLIGHT : SRC_STORED;
    src_a = (wr_fire_i && (addr_a_i == addr_b_i)) ? SRC_INFLIGHT : SRC_STORED;
  end

  assign next_a_o = pick_word(src_a, stored_a_i, wdata_i);
  assign next_b_o = pick_word(src_b, stored_b_i, wdata_i);

  AST_A_BYPASS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == SRC_INFLIGHT) |-> ((addr_a_i == addr_b_i) && (src_b == SRC_INFLIGHT))); // R3
  AST_IDLE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire_i |-> ((next_a_o == stored_a_i) && (next_b_o == stored_b_i))); // R4
endmodule

// File: rtl/tpr_out_latch.sv
module tpr_out_latch #(
  parameter int unsigned WIDTH     = twin_port_pkg::TP_WIDTH,
  parameter bit          HAS_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clr_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic clr_hit;

  assign clr_hit = HAS_CLEAR && !clr_n_i;

  // the clear wins over loading
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= '0;
    else if (clr_hit) q_o <= '0;
    else if (load_i)  q_o <= d_i;
  end

  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clr_hit) |=> $stable(q_o)); // R5
  AST_LOAD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_hit) |=> (q_o == $past(d_i))); // R5

  generate
    if (HAS_CLEAR) begin : g_clear_chk
      AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_i |=> (q_o == '0)); // R6
    end
  endgenerate
endmodule

// File: rtl/twin_port_regbank.sv
module twin_port_regbank
  import twin_port_pkg::*;
#(
  parameter int unsigned WORDS = TP_WORDS,
  parameter int unsigned WIDTH = TP_WIDTH,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_a,
  input  logic [AW-1:0]    addr_b,
  input  logic [WIDTH-1:0] din,
  input  logic             wr0_n,
  input  logic             wr1_n,
  input  logic             lat_open,
  input  logic             clr_a_n,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  output logic [WIDTH-1:0] qa,
  output logic             qa_vld,
  output logic [WIDTH-1:0] qb,
  output logic             qb_vld
);
  logic             wr_fire;
  logic [WIDTH-1:0] stored_a;
  logic [WIDTH-1:0] stored_b;
  logic [WIDTH-1:0] next_a;
  logic [WIDTH-1:0] next_b;
  logic [WIDTH-1:0] lat_a;
  logic [WIDTH-1:0] lat_b;

  tpr_storage #(.WORDS(WORDS), .WIDTH(WIDTH)) u_storage (
    .clk       (clk),
    .rst_n     (rst_n),
    .waddr_i   (addr_b),
    .raddr_a_i (addr_a),
    .wdata_i   (din),
    .wr0_n_i   (wr0_n),
    .wr1_n_i   (wr1_n),
    .wr_fire_o (wr_fire),
    .rdata_a_o (stored_a),
    .rdata_b_o (stored_b)
  );

  tpr_bypass #(.WORDS(WORDS), .WIDTH(WIDTH)) u_bypass (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_a_i   (addr_a),
    .addr_b_i   (addr_b),
    .wr_fire_i  (wr_fire),
    .wdata_i    (din),
    .stored_a_i (stored_a),
    .stored_b_i (stored_b),
    .next_a_o   (next_a),
    .next_b_o   (next_b)
  );

  tpr_out_latch #(.WIDTH(WIDTH), .HAS_CLEAR(1'b1)) u_lat_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (lat_open),
    .clr_n_i (clr_a_n),
    .d_i     (next_a),
    .q_o     (lat_a)
  );

  tpr_out_latch #(.WIDTH(WIDTH), .HAS_CLEAR(1'b0)) u_lat_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (lat_open),
    .clr_n_i (1'b1),
    .d_i     (next_b),
    .q_o     (lat_b)
  );

  assign qa_vld = ~oe_a_n;
  assign qb_vld = ~oe_b_n;
  assign qa     = qa_vld ? lat_a : '0;
  assign qb     = qb_vld ? lat_b : '0;

  AST_B_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && lat_open) |=> (lat_b == $past(din))); // R3
  AST_B_IGNORES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_a_n && !lat_open) |=> $stable(lat_b)); // R6
endmodule

// File: tb/twin_port_regbank_bench.sv
module twin_port_regbank_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr_a = '0, addr_b = '0, din = '0;
  logic       wr0_n = 1'b1, wr1_n = 1'b1, lat_open = 1'b0;
  logic       clr_a_n = 1'b1, oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic [3:0] qa, qb;
  logic       qa_vld, qb_vld;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  twin_port_regbank u_twin_port_regbank (
    .clk(clk), .rst_n(rst_n), .addr_a(addr_a), .addr_b(addr_b), .din(din),
    .wr0_n(wr0_n), .wr1_n(wr1_n), .lat_open(lat_open), .clr_a_n(clr_a_n),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .qa(qa), .qa_vld(qa_vld),
    .qb(qb), .qb_vld(qb_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] pat(int i);
    return 4'((i * 7 + 3) & 15);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 qa after reset", qa, 4'h0);
    chk("R1 qb after reset", qb, 4'h0);
    chk("R7 valid flags enabled", {2'b0, qa_vld, qb_vld}, 4'h3);
  endtask

  task automatic t_fill_and_read();
    lat_open = 1'b0;
    for (int i = 0; i < 16; i++) begin
      addr_b = 4'(i); din = pat(i); wr0_n = 1'b0; wr1_n = 1'b0;
      tick();
    end
    wr0_n = 1'b1; wr1_n = 1'b1;
    chk("R5 closed latches unchanged during fill", qb, 4'h0);
    lat_open = 1'b1;
    for (int i = 0; i < 16; i++) begin
      addr_a = 4'(i); addr_b = 4'(15 - i);
      tick();
      chk("R4 port A read", qa, pat(i));
      chk("R4 port B read", qb, pat(15 - i));
    end
  endtask

  task automatic t_single_strobe();
    lat_open = 1'b1; addr_a = 4'd3; addr_b = 4'd3; din = 4'h7;
    wr0_n = 1'b0; wr1_n = 1'b1; tick();
    wr0_n = 1'b1; wr1_n = 1'b0; tick();
    wr0_n = 1'b1; wr1_n = 1'b1; tick();
    chk("R2 one strobe does not write (A)", qa, pat(3));
    chk("R2 one strobe does not write (B)", qb, pat(3));
  endtask

  task automatic t_write_through();
    lat_open = 1'b1; addr_a = 4'd7; addr_b = 4'd7; din = 4'hA;
    wr0_n = 1'b0; wr1_n = 1'b0; tick();
    chk("R3 A sees inflight on match", qa, 4'hA);
    chk("R3 B sees inflight", qb, 4'hA);
    addr_a = 4'd2; din = 4'hC; tick();
    chk("R3 A stored on mismatch", qa, pat(2));
    chk("R3 B sees inflight", qb, 4'hC);
    wr0_n = 1'b1; wr1_n = 1'b1; addr_a = 4'd7; din = 4'h0; tick();
    chk("R2 last write stored", qa, 4'hC);
    chk("R4 B stored after write", qb, 4'hC);
  endtask

  task automatic t_hold_over_write();
    lat_open = 1'b1; addr_a = 4'd4; addr_b = 4'd4; tick();
    chk("R5 load A", qa, pat(4));
    lat_open = 1'b0; addr_a = 4'd0; din = 4'h5;
    wr0_n = 1'b0; wr1_n = 1'b0; tick();
    wr0_n = 1'b1; wr1_n = 1'b1; tick();
    chk("R5 A holds through write", qa, pat(4));
    chk("R5 B holds through write", qb, pat(4));
    lat_open = 1'b1; addr_a = 4'd4; tick();
    chk("R2 write under held latch landed", qa, 4'h5);
  endtask

  task automatic t_clear();
    lat_open = 1'b1; addr_a = 4'd5; addr_b = 4'd6; tick();
    chk("R4 preload A", qa, pat(5));
    lat_open = 1'b0; clr_a_n = 1'b0; tick();
    chk("R6 clear while holding", qa, 4'h0);
    chk("R6 B untouched by clear", qb, pat(6));
    clr_a_n = 1'b1; tick();
    chk("R6 stays zero while closed", qa, 4'h0);
    lat_open = 1'b1; clr_a_n = 1'b0; tick();
    chk("R6 clear beats load", qa, 4'h0);
    chk("R5 B loads beside clear", qb, pat(6));
    clr_a_n = 1'b1; tick();
    chk("R6 reload after clear", qa, pat(5));
    lat_open = 1'b0; oe_a_n = 1'b1; clr_a_n = 1'b0; tick();
    clr_a_n = 1'b1; oe_a_n = 1'b0; #1;
    chk("R6 clear with output disabled", qa, 4'h0);
  endtask

  task automatic t_output_enable();
    lat_open = 1'b1; addr_a = 4'd1; addr_b = 4'd1; tick();
    lat_open = 1'b0;
    oe_a_n = 1'b1; #1;
    chk("R7 A valid low", {3'b0, qa_vld}, 4'h0);
    chk("R7 A data zero", qa, 4'h0);
    chk("R7 B still valid", qb, pat(1));
    oe_b_n = 1'b1; #1;
    chk("R7 B valid low", {3'b0, qb_vld}, 4'h0);
    chk("R7 B data zero", qb, 4'h0);
    tick();
    oe_a_n = 1'b0; oe_b_n = 1'b0; #1;
    chk("R7 A content kept", qa, pat(1));
    chk("R7 B content kept", qb, pat(1));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_and_read();
    t_single_strobe();
    t_write_through();
    t_hold_over_write();
    t_clear();
    t_output_enable();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule